// File: doc/BRIEF.md
# Power-Up Strap Capture and Mode Latch

This block is the configuration front end of a multi-output clock generator. Three shared pads start out as high-impedance inputs while the supply ramps. Once power-good is seen, a parameterized settling interval runs. At its end the pad levels are captured into internal registers, the pads' output drivers are enabled, and the pads carry clock outputs from then on. A dedicated rate-select input is captured at the same moment.

From the captured values the block produces a two-bit frequency-plan code for the host and peripheral clock domains. It also produces a flag for the one plan that runs the peripheral domain fast, a spread-spectrum enable, and a select that sets the auxiliary output to 24 or 48 MHz. These mode outputs stay fixed for as long as power-good stays high. When power-good falls, the block returns to its unconfigured state. The next rise runs the whole settle-and-capture sequence again.

Strap bit positions are as follows. Bit 0 is the high-frequency strap, bit 1 is the active-low spread strap, and bit 2 is the auxiliary-rate strap. Unconnected pads read as 1 through weak pull-ups. The rate-select input has no pull-up and must be driven.

Top module: `cfg_strap_capture`

## Requirements
- R1: After reset, and at every time `ready` is 0, the outputs `pin_oe`, `freq_code`, `periph_fast`, `spread_en` and `aux_24` are all 0.
- R2: `ready` and every bit of `pin_oe` become 1 on the clock edge that is SETTLE_CYCLES+1 edges after the first edge that samples `pwr_good` high. They are still 0 after SETTLE_CYCLES edges.
- R3: Straps and `rate_sel` are captured on the edge where `ready` rises. Later changes on `strap_pin` or `rate_sel` do not affect any mode output while `pwr_good` stays high.
- R4: `freq_code` = {~hfs, sel}, where hfs is captured strap bit 0 and sel is captured `rate_sel`. The codes are: 00 = 66.6/33.3 MHz, 01 = 100/33.3 MHz, 10 = 150/37.5 MHz, 11 = 133.3/33.3 MHz (host/peripheral).
- R5: `periph_fast` is 1 only for code 10, the plan with a 37.5 MHz peripheral clock.
- R6: `spread_en` is the inverse of captured strap bit 1. A strap of 0 enables spreading.
- R7: `aux_24` equals captured strap bit 2. A value of 1 selects 24 MHz and 0 selects 48 MHz.
- R8: When `pwr_good` is sampled low, `ready`, `pin_oe` and all mode outputs are 0 after that edge.
- R9: If `pwr_good` drops during the settling interval, no capture takes place. The next rise restarts the full interval and captures the pad values present at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| pwr_good | input | 1 | Supply-good indication, synchronous to clk |
| strap_pin | input | 3 | Pad levels seen while the pads are inputs |
| rate_sel | input | 1 | Dedicated 100/66 select, externally driven |
| pin_oe | output | 3 | Output enable for each shared pad |
| ready | output | 1 | Configuration captured and valid |
| freq_code | output | 2 | Frequency-plan code |
| periph_fast | output | 1 | Peripheral domain at 37.5 MHz |
| spread_en | output | 1 | Spread-spectrum modulation enable |
| aux_24 | output | 1 | Auxiliary output at 24 MHz (0: 48 MHz) |

## Verification
The hardest condition to reach from the ports is a power-good drop in the middle of the settling interval, followed by a fresh rise with different pad values. That is the only way to show the count restarted rather than resumed, and that nothing was captured on the aborted attempt. The stimulus raises power-good, lowers it a few cycles into the interval, and then powers up again with other straps. It expects `ready` exactly SETTLE_CYCLES+1 edges after the second rise, with the second set of values. The ignore rule is exercised by inverting every pad and the select right after each capture and confirming the mode outputs hold.

// File: rtl/strap_pkg.sv
package strap_pkg;

   typedef enum logic [1:0] {
      PH_OFF    = 2'd0,
      PH_SETTLE = 2'd1,
      PH_RUN    = 2'd2
   } phase_e;

   localparam int unsigned STRAP_COUNT  = 3;
   localparam int unsigned STRAP_HFS    = 0;
   localparam int unsigned STRAP_SPRD_N = 1;
   localparam int unsigned STRAP_AUX    = 2;

   typedef struct packed {
      logic [1:0] code;
      logic       periph_fast;
      logic       spread_en;
      logic       aux_24;
   } mode_t;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int unsigned SETTLE_CYCLES = 8,
   localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || done) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/strap_regs.sv
module strap_regs #(
   parameter int unsigned      WIDTH   = 3,
   parameter logic [WIDTH-1:0] DEFAULT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             clear,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q[i] <= DEFAULT[i];
         end else if (clear) begin
            q[i] <= DEFAULT[i];
         end else if (capture) begin
            q[i] <= d[i];
         end
      end
   end

endmodule

// File: rtl/mode_decode.sv
module mode_decode
   import strap_pkg::*;
(
   input  logic  valid,
   input  logic  hfs,
   input  logic  sel,
   input  logic  spread_n,
   input  logic  aux,
   output mode_t mode
);

   always_comb begin
      mode = '0;
      if (valid) begin
         mode.code        = {~hfs, sel};
         mode.periph_fast = ~hfs & ~sel;
         mode.spread_en   = ~spread_n;
         mode.aux_24      = aux;
      end
   end

endmodule

// File: rtl/cfg_strap_capture.sv
module cfg_strap_capture
   import strap_pkg::*;
#(
   parameter int unsigned                  SETTLE_CYCLES = 8,
   parameter bit                           LATCH_SEL     = 1'b1,
   parameter logic [STRAP_COUNT-1:0]       STRAP_DEFAULT = '1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pwr_good,
   input  logic [STRAP_COUNT-1:0] strap_pin,
   input  logic                   rate_sel,
   output logic [STRAP_COUNT-1:0] pin_oe,
   output logic                   ready,
   output logic [1:0]             freq_code,
   output logic                   periph_fast,
   output logic                   spread_en,
   output logic                   aux_24
);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end
   if (STRAP_COUNT != 3) begin : g_bad_count
      $error("strap decode expects three straps");
   end

   phase_e                 phase;
   phase_e                 phase_nx;
   logic                   settle_done;
   logic                   capture;
   logic                   clear;
   logic [STRAP_COUNT-1:0] strap_q;
   logic                   sel_eff;
   mode_t                  mode;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_OFF:    if (pwr_good) phase_nx = PH_SETTLE;
         PH_SETTLE: begin
            if (!pwr_good)        phase_nx = PH_OFF;
            else if (settle_done) phase_nx = PH_RUN;
         end
         PH_RUN:    if (!pwr_good) phase_nx = PH_OFF;
         default:   phase_nx = PH_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_OFF;
      else        phase <= phase_nx;
   end

   assign capture = (phase == PH_SETTLE) && pwr_good && settle_done;
   assign clear   = !pwr_good;

   settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (phase == PH_SETTLE),
      .done  (settle_done)
   );

   strap_regs #(.WIDTH(STRAP_COUNT), .DEFAULT(STRAP_DEFAULT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .clear   (clear),
      .d       (strap_pin),
      .q       (strap_q)
   );

   if (LATCH_SEL) begin : g_sel_latch
      logic sel_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       sel_q <= 1'b0;
         else if (clear)   sel_q <= 1'b0;
         else if (capture) sel_q <= rate_sel;
      end
      assign sel_eff = sel_q;
   end else begin : g_sel_live
      assign sel_eff = rate_sel;
   end

   assign ready  = (phase == PH_RUN);
   assign pin_oe = {STRAP_COUNT{ready}};

   mode_decode u_dec (
      .valid    (ready),
      .hfs      (strap_q[STRAP_HFS]),
      .sel      (sel_eff),
      .spread_n (strap_q[STRAP_SPRD_N]),
      .aux      (strap_q[STRAP_AUX]),
      .mode     (mode)
   );

   assign freq_code   = mode.code;
   assign periph_fast = mode.periph_fast;
   assign spread_en   = mode.spread_en;
   assign aux_24      = mode.aux_24;

endmodule

// File: rtl/strap_capture_checker.sv
module strap_capture_checker #(
   parameter int unsigned SETTLE_CYCLES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_good,
   input logic [2:0] pin_oe,
   input logic       ready,
   input logic [1:0] freq_code,
   input logic       periph_fast,
   input logic       spread_en,
   input logic       aux_24
);

   localparam int unsigned CW = $clog2(SETTLE_CYCLES + 3);
   localparam logic [CW-1:0] SAT = CW'(SETTLE_CYCLES + 1);

   logic [CW-1:0] pg_run;

   always_ff @(posedge clk) begin
      if (!rst_n)            pg_run <= '0;
      else if (!pwr_good)    pg_run <= '0;
      else if (pg_run < SAT) pg_run <= pg_run + 1'b1;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (freq_code == 2'b00) && !periph_fast && !spread_en && !aux_24 && (pin_oe == 3'b000));

   p_settle_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (pg_run > CW'(SETTLE_CYCLES)));

   p_oe_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe != 3'b000) |-> ready);

   p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready)) |-> ($stable(freq_code) && $stable(periph_fast)
                                   && $stable(spread_en) && $stable(aux_24)));

   p_fast_plan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      periph_fast |-> (freq_code == 2'b10));

   p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !ready);

endmodule

bind cfg_strap_capture strap_capture_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_good    (pwr_good),
   .pin_oe      (pin_oe),
   .ready       (ready),
   .freq_code   (freq_code),
   .periph_fast (periph_fast),
   .spread_en   (spread_en),
   .aux_24      (aux_24)
);

// File: tb/sim_cfg_strap_capture.sv
module sim_cfg_strap_capture;

   localparam int unsigned S = 8;

   typedef struct packed {
      logic [1:0] code;
      logic       pf;
      logic       spr;
      logic       aux;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_good = 1'b0;
   logic [2:0] strap_pin = 3'b111;
   logic       rate_sel = 1'b0;
   logic [2:0] pin_oe;
   logic       ready;
   logic [1:0] freq_code;
   logic       periph_fast;
   logic       spread_en;
   logic       aux_24;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   exp_t sb_q[$];
   exp_t last_exp;

   always #4 clk = ~clk;

   cfg_strap_capture #(.SETTLE_CYCLES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_pin(strap_pin),
      .rate_sel(rate_sel), .pin_oe(pin_oe), .ready(ready), .freq_code(freq_code),
      .periph_fast(periph_fast), .spread_en(spread_en), .aux_24(aux_24)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [2:0] st, input logic sel);
      exp_t e;
      e.code = {~st[0], sel};
      e.pf   = ~st[0] & ~sel;
      e.spr  = ~st[1];
      e.aux  = st[2];
      return e;
   endfunction

   task automatic check_mode(input string tag, input exp_t e);
      chk({tag, " R4 code"}, freq_code, e.code);
      chk({tag, " R5 fast"}, periph_fast, e.pf);
      chk({tag, " R6 spread"}, spread_en, e.spr);
      chk({tag, " R7 aux"}, aux_24, e.aux);
   endtask

   // Driver: sets pads, raises power-good, pushes the expected item, checks latency.
   task automatic power_up(input logic [2:0] st, input logic sel);
      @(negedge clk);
      strap_pin = st;
      rate_sel  = sel;
      pwr_good  = 1'b1;
      last_exp  = model(st, sel);
      sb_q.push_back(last_exp);
      repeat (S) @(negedge clk);
      chk("R2 ready before interval", ready, 1'b0);
      chk("R2 oe before interval", pin_oe, 3'b000);
      @(negedge clk);
      chk("R2 ready after interval", ready, 1'b1);
      chk("R2 oe after interval", pin_oe, 3'b111);
   endtask

   task automatic power_down();
      @(negedge clk);
      pwr_good = 1'b0;
      @(negedge clk);
      chk("R8 ready cleared", ready, 1'b0);
      chk("R8 oe cleared", pin_oe, 3'b000);
      chk("R1 code idle", freq_code, 2'b00);
      chk("R1 flags idle", {periph_fast, spread_en, aux_24}, 3'b000);
   endtask

   // Monitor: pops one expected item on every rise of ready and compares.
   initial begin : monitor
      logic prev;
      exp_t e;
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (ready && !prev) begin
            if (sb_q.size() == 0) begin
               chk("R2 unexpected ready", 1'b1, 1'b0);
            end else begin
               e = sb_q.pop_front();
               check_mode("scoreboard", e);
            end
         end
         prev = ready;
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 reset ready", ready, 1'b0);
      chk("R1 reset oe", pin_oe, 3'b000);
      chk("R1 reset code", freq_code, 2'b00);
      chk("R1 reset flags", {periph_fast, spread_en, aux_24}, 3'b000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle without power", ready, 1'b0);

      // Every strap combination with both select values.
      for (int i = 0; i < 16; i++) begin
         power_up(i[2:0], i[3]);
         @(negedge clk);
         strap_pin = ~i[2:0];
         rate_sel  = ~i[3];
         repeat (3) @(negedge clk);
         check_mode("R3 ignore later pads", last_exp);
         chk("R3 still ready", ready, 1'b1);
         power_down();
      end

      // Unconnected pads (all ones): 66.6 MHz plan, no spread, 24 MHz aux.
      power_up(3'b111, 1'b0);
      check_mode("default pads", model(3'b111, 1'b0));
      power_down();

      // Abort in the middle of the settling interval.
      @(negedge clk);
      strap_pin = 3'b000;
      rate_sel  = 1'b0;
      pwr_good  = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 no ready mid interval", ready, 1'b0);
      pwr_good = 1'b0;
      @(negedge clk);
      chk("R9 still idle after drop", ready, 1'b0);
      power_up(3'b101, 1'b1);
      check_mode("R9 recapture", model(3'b101, 1'b1));
      power_down();

      repeat (2) @(negedge clk);
      chk("R2 scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule